// File: doc/BRIEF.md
# Bit-Band Alias Access Bridge

This bridge sits between a single 32-bit bus master and a byte-lane SRAM that has one cycle of read latency. Addresses inside the RAM window go straight through to the SRAM as byte, half-word or word accesses. Addresses inside the larger alias window stand for single bits: each 32-bit alias word names one bit of one byte in the RAM window.

An alias read returns the selected bit as a zero-extended word. An alias write replaces only that bit. The bridge does this with a read followed by a write of the same SRAM word, and it holds the master with `m_ready` low until the write has been issued, so nothing can come between the two cycles. Any address outside both windows completes at once with zero data and a one-cycle error flag.

A request is held stable by the master from the cycle `m_valid` rises until the first rising edge at which `m_ready` is high. That edge completes it.

Top module: `bitband_bridge`

## Requirements
- R1: A RAM-window write completes in the cycle it is presented (`m_ready` high) with exactly one SRAM write. The lane enables are set by `m_size` (0 byte, 1 half-word, 2 or 3 word) and by the low address bits (byte lane = `addr[1:0]`, half-word lanes = `addr[1]` ? 1100 : 0011). `m_wdata` is passed through on its own byte lanes.
- R2: A RAM-window read issues one SRAM read, keeps `m_ready` low in its first cycle, and completes in the next cycle with the whole SRAM word on `m_rdata`.
- R3: An alias address decodes as follows. Byte offset = (addr − alias base) >> 5. Bit number = addr[4:2], from 0 to 7. The selected byte sits on lane byteoffset[1:0] of SRAM word byteoffset >> 2. With the default bases, alias 0x22006008 selects bit 2 of the byte at 0x20000300.
- R4: An alias read completes in its second cycle and returns 0x00000001 when the selected bit is set and 0x00000000 when it is clear.
- R5: An alias write stores bit 0 of `m_wdata` into the selected bit. All other bits of the word are unchanged.
- R6: An alias write makes exactly two SRAM cycles: a read, then a write to the same word with a single lane enabled. `m_ready` is low in the first cycle and high in the second. The second cycle uses the location latched in the first, even if the master's signals change.
- R7: For alias accesses, `addr[1:0]` and `m_size` are ignored.
- R8: An address in neither window completes in one cycle with `m_err` high, `m_rdata` zero and no SRAM access.
- R9: During and after reset, with no request pending, `mem_en`, `m_ready` and `m_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_valid | input | 1 | Master request pending |
| m_write | input | 1 | 1 = write, 0 = read |
| m_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| m_addr | input | 32 | Byte address |
| m_wdata | input | 32 | Write data on its byte lanes |
| m_ready | output | 1 | Request completes at the next rising edge |
| m_rdata | output | 32 | Read data, valid when `m_ready` is high |
| m_err | output | 1 | Unmapped address, valid with `m_ready` |
| mem_en | output | 1 | SRAM access this cycle |
| mem_we | output | 1 | SRAM write strobe |
| mem_addr | output | RAM_AW-2 | SRAM word index |
| mem_be | output | 4 | SRAM byte-lane enables |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after the read |

## Verification
Alias traffic is aimed at bits that are set and at bits that are clear, on every byte lane. This separates a correct lane or bit selection from an off-by-one in the decode. Alias writes set bits and clear bits, some with write data whose upper bits contradict bit 0, to show that only bit 0 matters and that neighbouring bits survive. Normal byte, half-word and word writes are read back as whole words, which exposes wrong lane enables. The window edges are covered: the last alias word, the first address past it, and an address between the windows. One alias write has its address changed halfway through, which shows whether the write half uses the latched location.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] RAM_BASE   = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          RAM_AW     = 12,
  localparam int         WAW        = RAM_AW - 2,
  localparam int         ALIAS_AW   = RAM_AW + 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            m_valid,
  input  logic            m_write,
  input  logic [1:0]      m_size,
  input  logic [31:0]     m_addr,
  input  logic [31:0]     m_wdata,
  output logic            m_ready,
  output logic [31:0]     m_rdata,
  output logic            m_err,
  output logic            mem_en,
  output logic            mem_we,
  output logic [WAW-1:0]  mem_addr,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RD = 2'd1, S_RMW = 2'd2} state_t;

  state_t         state;
  logic [4:0]     pos_q;
  logic [WAW-1:0] word_q;
  logic           bit_q;
  logic           alias_q;

  wire in_ram   = m_addr[31:RAM_AW]   == RAM_BASE[31:RAM_AW];
  wire in_alias = m_addr[31:ALIAS_AW] == ALIAS_BASE[31:ALIAS_AW];

  wire [WAW-1:0] n_word = m_addr[RAM_AW-1:2];
  wire [WAW-1:0] a_word = m_addr[ALIAS_AW-1:7];
  wire [4:0]     a_pos  = m_addr[6:2];

  logic [3:0]  n_be;
  logic [31:0] rmw_data;

  always_comb begin
    case (m_size)
      2'd0:    n_be = 4'b0001 << m_addr[1:0];
      2'd1:    n_be = m_addr[1] ? 4'b1100 : 4'b0011;
      default: n_be = 4'b1111;
    endcase
  end

  always_comb begin
    rmw_data        = mem_rdata;
    rmw_data[pos_q] = bit_q;
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = 4'b0000;
    mem_wdata = '0;
    m_ready   = 1'b0;
    m_rdata   = '0;
    m_err     = 1'b0;
    case (state)
      S_IDLE: if (m_valid) begin
        if (in_ram) begin
          mem_en    = 1'b1;
          mem_we    = m_write;
          mem_addr  = n_word;
          mem_be    = m_write ? n_be : 4'b1111;
          mem_wdata = m_wdata;
          m_ready   = m_write;
        end else if (in_alias) begin
          mem_en   = 1'b1;
          mem_addr = a_word;
          mem_be   = 4'b1111;
        end else begin
          m_ready = 1'b1;
          m_err   = 1'b1;
        end
      end
      S_RD: begin
        m_ready = 1'b1;
        m_rdata = alias_q ? {31'b0, mem_rdata[pos_q]} : mem_rdata;
      end
      S_RMW: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = word_q;
        mem_be    = 4'b0001 << pos_q[4:3];
        mem_wdata = rmw_data;
        m_ready   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pos_q   <= '0;
      word_q  <= '0;
      bit_q   <= 1'b0;
      alias_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (m_valid) begin
          if (in_ram) begin
            alias_q <= 1'b0;
            if (!m_write) state <= S_RD;
          end else if (in_alias) begin
            alias_q <= 1'b1;
            pos_q   <= a_pos;
            word_q  <= a_word;
            bit_q   <= m_wdata[0];
            state   <= m_write ? S_RMW : S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        m_valid,
  input logic        m_ready,
  input logic        m_err,
  input logic [31:0] m_rdata,
  input logic        mem_en,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata,
  input logic [1:0]  st,
  input logic        alias_q
);

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> (m_ready && m_rdata == 32'h0 && !mem_en)); // R8

  AST_RMW_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> $past(mem_en && !mem_we)); // R6

  AST_RMW_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> (mem_en && mem_we && $countones(mem_be) == 1 && m_ready)); // R6

  AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> ($countones(mem_wdata ^ mem_rdata) <= 1)); // R5

  AST_READ_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> m_ready); // R2

  AST_ALIAS_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && alias_q) |-> (m_rdata[31:1] == 31'h0)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !m_valid) |-> (!m_ready && !mem_en && !m_err)); // R9

endmodule

bind bitband_bridge bitband_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_err(m_err), .m_rdata(m_rdata), .mem_en(mem_en), .mem_we(mem_we),
  .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
  .st(state), .alias_q(alias_q)
);

// File: tb/bitband_bridge_tb_top.sv
module bitband_bridge_tb_top;
  localparam int RAM_AW = 12;
  localparam int WAW    = RAM_AW - 2;
  localparam int NV     = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_valid = 1'b0, m_write = 1'b0;
  logic [1:0]  m_size = 2'd2;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic m_ready, m_err;
  logic [31:0] m_rdata;
  logic mem_en, mem_we;
  logic [WAW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [31:0] sram [0:(1<<WAW)-1];

  int n_total = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  bitband_bridge #(.RAM_AW(RAM_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write),
    .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready),
    .m_rdata(m_rdata), .m_err(m_err), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= sram[mem_addr];
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) sram[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  // {wr, addr, size, wdata, exp_rdata, exp_err, exp_cycles, exp_mem_ops}
  localparam logic [103:0] VEC [0:NV-1] = '{
    {1'b1, 32'h2000_0300, 2'd2, 32'hA5A5_5A5A, 32'h0,         1'b0, 2'd1, 2'd1},
    {1'b0, 32'h2000_0300, 2'd2, 32'h0,         32'hA5A5_5A5A, 1'b0, 2'd2, 2'd1},
    {1'b0, 32'h2200_6008, 2'd2, 32'h0,         32'h0,         1'b0, 2'd2, 2'd1},
    {1'b0, 32'h2200_6004, 2'd2, 32'h0,         32'h1,         1'b0, 2'd2, 2'd1},
    {1'b1, 32'h2200_6008, 2'd2, 32'h1,         32'h0,         1'b0, 2'd2, 2'd2},
    {1'b0, 32'h2000_0300, 2'd2, 32'h0,         32'hA5A5_5A5E, 1'b0, 2'd2, 2'd1},
    {1'b1, 32'h2200_607C, 2'd2, 32'hFFFF_FFFE, 32'h0,         1'b0, 2'd2, 2'd2},
    {1'b0, 32'h2000_0300, 2'd2, 32'h0,         32'h25A5_5A5E, 1'b0, 2'd2, 2'd1},
    {1'b0, 32'h2200_607F, 2'd0, 32'h0,         32'h0,         1'b0, 2'd2, 2'd1},
    {1'b1, 32'h2000_0301, 2'd0, 32'h0000_FF00, 32'h0,         1'b0, 2'd1, 2'd1},
    {1'b0, 32'h2000_0300, 2'd2, 32'h0,         32'h25A5_FF5E, 1'b0, 2'd2, 2'd1},
    {1'b1, 32'h2000_0302, 2'd1, 32'h1234_0000, 32'h0,         1'b0, 2'd1, 2'd1},
    {1'b0, 32'h2000_0300, 2'd2, 32'h0,         32'h1234_FF5E, 1'b0, 2'd2, 2'd1},
    {1'b0, 32'h2200_6050, 2'd2, 32'h0,         32'h1,         1'b0, 2'd2, 2'd1},
    {1'b0, 32'h3000_0000, 2'd2, 32'h0,         32'h0,         1'b1, 2'd1, 2'd0},
    {1'b1, 32'h2100_0000, 2'd2, 32'hDEAD_BEEF, 32'h0,         1'b1, 2'd1, 2'd0},
    {1'b1, 32'h2201_FFFC, 2'd1, 32'h1,         32'h0,         1'b0, 2'd2, 2'd2},
    {1'b0, 32'h2000_0FFC, 2'd2, 32'h0,         32'h8000_0000, 1'b0, 2'd2, 2'd1},
    {1'b0, 32'h2202_0000, 2'd2, 32'h0,         32'h0,         1'b1, 2'd1, 2'd0},
    {1'b1, 32'h2200_600D, 2'd0, 32'h0,         32'h0,         1'b0, 2'd2, 2'd2},
    {1'b0, 32'h2000_0300, 2'd2, 32'h0,         32'h1234_FF56, 1'b0, 2'd2, 2'd1}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_acc(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic er, output int cyc, output int ops);
    logic r;
    @(negedge clk);
    m_valid = 1'b1; m_write = wr; m_addr = a; m_size = sz; m_wdata = wd;
    cyc = 0; ops = 0;
    do begin
      #1;
      r = m_ready; rd = m_rdata; er = m_err;
      if (mem_en) ops++;
      @(posedge clk);
      cyc++;
      if (!r) @(negedge clk);
    end while (!r && cyc < 8);
    @(negedge clk);
    m_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    int cyc, ops;
    for (int i = 0; i < (1 << WAW); i++) sram[i] = '0;

    repeat (3) @(negedge clk);
    // R9: quiet while in reset
    check(!mem_en && !m_ready && !m_err, "R9 reset outputs",
          {29'b0, mem_en, m_ready, m_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!mem_en && !m_ready && !m_err, "R9 idle after reset",
          {29'b0, mem_en, m_ready, m_err}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [103:0] e;
      logic is_alias;
      e = VEC[v];
      is_alias = e[102:71] >= 32'h2200_0000 && e[102:71] < 32'h2202_0000;
      do_acc(e[103], e[102:71], e[70:69], e[68:37], rd, er, cyc, ops);
      if (!e[103] && !e[4])
        check(rd === e[36:5], is_alias ? "R4 R3 R7 alias read data" : "R2 normal read data",
              rd, e[36:5]);
      if (e[4])
        check(rd === 32'h0, "R8 unmapped data zero", rd, 32'h0);
      check(er === e[4], "R8 error flag", {31'b0, er}, {31'b0, e[4]});
      check(cyc == int'(e[3:2]), is_alias ? "R6 R4 alias cycle count" : "R1 R2 R8 cycle count",
            cyc, {30'b0, e[3:2]});
      check(ops == int'(e[1:0]), is_alias && e[103] ? "R6 R5 alias write mem ops" : "R1 R2 R8 mem ops",
            ops, {30'b0, e[1:0]});
      #1;
      check(!m_err && !mem_en, "R9 idle between requests", {30'b0, m_err, mem_en}, 32'h0);
    end

    // R6: alias write clearing bit 5 of byte 0x301, master changes address mid-way
    @(negedge clk);
    m_valid = 1'b1; m_write = 1'b1; m_size = 2'd2;
    m_addr = 32'h2200_6034; m_wdata = 32'h0;
    #1;
    check(mem_en && !mem_we && !m_ready && mem_addr == 10'h0C0,
          "R6 first cycle read", {mem_en, mem_we, m_ready, 19'b0, mem_addr}, {3'b100, 19'b0, 10'h0C0});
    @(posedge clk);
    @(negedge clk);
    m_addr = 32'h2000_0000; m_write = 1'b0; m_wdata = 32'hFFFF_FFFF;
    #1;
    check(mem_en && mem_we && m_ready && mem_addr == 10'h0C0 && mem_be == 4'b0010,
          "R6 second cycle write latched",
          {mem_en, mem_we, m_ready, 15'b0, mem_be, mem_addr},
          {3'b111, 15'b0, 4'b0010, 10'h0C0});
    @(posedge clk);
    @(negedge clk);
    m_valid = 1'b0;
    do_acc(1'b0, 32'h2000_0300, 2'd2, 32'h0, rd, er, cyc, ops);
    check(rd === 32'h1234_DF56, "R5 R6 only target bit cleared", rd, 32'h1234_DF56);
    do_acc(1'b0, 32'h2200_6034, 2'd2, 32'h0, rd, er, cyc, ops);
    check(rd === 32'h0, "R4 cleared bit reads zero", rd, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule